// File: doc/BRIEF.md
# Vector Post-Processing Unit with Writeback Routing

This block sits behind a matrix multiply-accumulate engine. It takes one command at a time. Each command names an operation, a source vector in the accumulation buffer, an optional second source vector, a destination address, a length and a final flag. The unit streams the source elements out of the accumulation buffer at one element per cycle and passes each through a fixed-point operation. The operation is normalization with scale, shift and bias, rectification, saturating elementwise addition, or a two-wide max pool with zero padding. The result vector is written to one of two places.

A result flagged as final leaves the unit. It is streamed into the unified output buffer while the reads are still running. A result not flagged as final is an intermediate value and returns to the accumulation buffer. Intermediate results are held in an internal staging store until every read of the command has been issued. Because of this, a command whose destination overlaps its own source always computes from the values that were present when it started. Both buffers are external synchronous memories: a read address presented in one cycle returns its data in the next.

Top module: `vec_post_unit`

## Requirements
- R1: During and right after synchronous active-low reset, cmd_ready is 1, done is 0, and neither write enable is asserted.
- R2: An accepted command with length L (1..MAX_LEN) asserts acc_rd_en for L consecutive cycles. Port A addresses run from the source address upward by one per cycle, and port B addresses run from the second source address upward in step.
- R3: Operation code 0 (normalize) produces saturate(((x*scale) >>> shift) + bias), clipped to the signed DW-bit range.
- R4: Operation code 1 (rectify) produces x when x is non-negative, and 0 otherwise.
- R5: Operation code 2 (add) produces saturate(x + y), where y is the element read on port B.
- R6: Operation code 3 (pool) produces max(x[i-1], x[i]), where the position before element 0 reads as zero.
- R7: A final command writes element i to the unified buffer at destination+i, in increasing address order, and never writes the accumulation buffer.
- R8: A non-final command writes element i to the accumulation buffer at destination+i, in increasing address order, and never writes the unified buffer.
- R9: A non-final command issues all of its accumulation writes only after its last read. An overlapping source and destination therefore yield results computed from the pre-command contents.
- R10: done is a single-cycle pulse in the cycle after the command's last write, and cmd_ready returns to 1 in the cycle after done. A command is accepted only when cmd_valid and cmd_ready are both 1.
- R11: A length of 0 completes with done and makes no reads or writes. A length above MAX_LEN is processed as MAX_LEN elements.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Unit idle, command accepted this cycle if valid |
| cmd_op | input | 2 | Operation: 0 normalize, 1 rectify, 2 add, 3 pool |
| cmd_final | input | 1 | 1: result to unified buffer, 0: back to accumulation buffer |
| cmd_src | input | AW | First source vector start address |
| cmd_src2 | input | AW | Second source vector start address (add) |
| cmd_dst | input | AW | Destination start address |
| cmd_len | input | LW | Element count |
| cmd_scale | input | DW | Signed normalization multiplier |
| cmd_shift | input | SW | Normalization right-shift amount |
| cmd_bias | input | DW | Signed normalization offset |
| acc_rd_en | output | 1 | Accumulation buffer read strobe (both ports) |
| acc_rd_addr_a | output | AW | Read address, first operand |
| acc_rd_data_a | input | DW | Read data, first operand, one cycle after address |
| acc_rd_addr_b | output | AW | Read address, second operand |
| acc_rd_data_b | input | DW | Read data, second operand, one cycle after address |
| acc_wr_en | output | 1 | Accumulation buffer write strobe |
| acc_wr_addr | output | AW | Accumulation buffer write address |
| acc_wr_data | output | DW | Accumulation buffer write data |
| ub_wr_en | output | 1 | Unified buffer write strobe |
| ub_wr_addr | output | AW | Unified buffer write address |
| ub_wr_data | output | DW | Unified buffer write data |
| done | output | 1 | Command complete pulse |

## Verification
The assertions check on every cycle that the two destinations are never written together and that accumulation writes never coincide with reads. They also check that read and write addresses step by one within a burst, that done lasts one cycle, comes with no write and is followed by the idle state, and that the unit comes out of reset idle. Only the bench's scenarios can show the arithmetic of each operation, including saturation at both limits, and the zero padding at the start of a pooled vector. The same holds for the element count under clamping and for the use of pre-command values when the source and destination overlap. The bench shows these by comparing buffer contents against values computed from a snapshot taken before each command.

// File: rtl/vpu_pkg.sv
// Shared types for the vector post-processing unit.
// Assumes: two-bit operation field decoded exactly as listed in the enum.
package vpu_pkg;
    typedef enum logic [1:0] {
        OP_NORM = 2'd0,
        OP_RELU = 2'd1,
        OP_ADD  = 2'd2,
        OP_POOL = 2'd3
    } vpu_op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_DRAIN,
        ST_WRITE,
        ST_DONE
    } vpu_state_e;
endpackage

// File: rtl/vpu_alu.sv
// Elementwise fixed-point operator for the post-processing unit.
// Purely combinational. Assumes signed DW-bit operands; prev is the element
// before xa in the vector (zero at the vector start) and is used only by pool.
module vpu_alu
    import vpu_pkg::*;
#(
    parameter int DW = 16,
    parameter int SW = 4
) (
    input  vpu_op_e                op,
    input  logic signed [DW-1:0]   xa,
    input  logic signed [DW-1:0]   xb,
    input  logic signed [DW-1:0]   prev,
    input  logic signed [DW-1:0]   scale,
    input  logic signed [DW-1:0]   bias,
    input  logic        [SW-1:0]   shift,
    output logic signed [DW-1:0]   y
);
    localparam int PW = 2 * DW + 1;
    localparam logic signed [PW-1:0] MAXV = {{(DW + 2){1'b0}}, {(DW - 1){1'b1}}};
    localparam logic signed [PW-1:0] MINV = {{(DW + 2){1'b1}}, {(DW - 1){1'b0}}};

    // Clip a wide signed value to the signed DW-bit range.
    function automatic logic signed [DW-1:0] sat(input logic signed [PW-1:0] v);
        if (v > MAXV)      return MAXV[DW-1:0];
        else if (v < MINV) return MINV[DW-1:0];
        else               return v[DW-1:0];
    endfunction

    logic signed [2*DW-1:0] prod;
    logic signed [2*DW-1:0] shifted;
    logic signed [PW-1:0]   norm_w;
    logic signed [PW-1:0]   sum_w;

    // Operation select with widened intermediates for saturation.
    always_comb begin
        prod    = (2*DW)'(xa) * (2*DW)'(scale);
        shifted = prod >>> shift;
        norm_w  = PW'(shifted) + PW'(bias);
        sum_w   = PW'(xa) + PW'(xb);
        case (op)
            OP_NORM: y = sat(norm_w);
            OP_RELU: y = xa[DW-1] ? '0 : xa;
            OP_ADD:  y = sat(sum_w);
            default: y = (xa > prev) ? xa : prev;
        endcase
    end
endmodule

// File: rtl/vpu_stage_buf.sv
// Staging store for intermediate results awaiting writeback.
// One synchronous write port, one combinational read port. Contents are not
// reset: every location read back is written earlier in the same command.
module vpu_stage_buf #(
    parameter int DW    = 16,
    parameter int DEPTH = 16,
    parameter int IW    = 4
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic [DW-1:0] wr_data,
    input  logic [IW-1:0] rd_idx,
    output logic [DW-1:0] rd_data
);
    logic [DW-1:0] mem [DEPTH];

    // Capture one result per cycle.
    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_idx] <= wr_data;
    end

    // Present the entry selected by the write-phase counter.
    always_comb rd_data = mem[rd_idx];
endmodule

// File: rtl/vpu_seq.sv
// Command sequencer and pipeline for the post-processing unit.
// Issues one read per cycle, aligns returning data with a one-stage valid,
// streams final results to the unified buffer, and parks intermediate results
// in the staging store until every read is done. Assumes memory read latency
// of exactly one cycle.
module vpu_seq
    import vpu_pkg::*;
#(
    parameter int AW      = 8,
    parameter int DW      = 16,
    parameter int SW      = 4,
    parameter int MAX_LEN = 16,
    parameter int LW      = $clog2(MAX_LEN + 1),
    parameter int IW      = (MAX_LEN > 1) ? $clog2(MAX_LEN) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    output logic          cmd_ready,
    input  vpu_op_e       cmd_op,
    input  logic          cmd_final,
    input  logic [AW-1:0] cmd_src,
    input  logic [AW-1:0] cmd_src2,
    input  logic [AW-1:0] cmd_dst,
    input  logic [LW-1:0] cmd_len,
    input  logic [DW-1:0] cmd_scale,
    input  logic [SW-1:0] cmd_shift,
    input  logic [DW-1:0] cmd_bias,
    output logic          rd_en,
    output logic [AW-1:0] rd_addr_a,
    output logic [AW-1:0] rd_addr_b,
    input  logic [DW-1:0] rd_data_a,
    output vpu_op_e       op_q,
    output logic [DW-1:0] scale_q,
    output logic [SW-1:0] shift_q,
    output logic [DW-1:0] bias_q,
    output logic [DW-1:0] prev_q,
    input  logic [DW-1:0] alu_y,
    output logic          stg_wr_en,
    output logic [IW-1:0] stg_wr_idx,
    output logic [IW-1:0] stg_rd_idx,
    input  logic [DW-1:0] stg_rd_data,
    output logic          acc_wr_en,
    output logic [AW-1:0] acc_wr_addr,
    output logic [DW-1:0] acc_wr_data,
    output logic          ub_wr_en,
    output logic [AW-1:0] ub_wr_addr,
    output logic [DW-1:0] ub_wr_data,
    output logic          done
);
    localparam logic [LW-1:0] LEN_CAP = LW'(MAX_LEN);

    vpu_state_e    state;
    logic          fin_q;
    logic [AW-1:0] src_q, src2_q, dst_q;
    logic [LW-1:0] len_q, rd_ctr, wr_ctr;
    logic          v1, v2;
    logic [IW-1:0] idx1, idx2;
    logic [DW-1:0] out_q;
    logic [LW-1:0] len_eff;
    logic          accept;

    // Acceptance and length clamping.
    always_comb begin
        accept  = cmd_valid && (state == ST_IDLE);
        len_eff = (cmd_len > LEN_CAP) ? LEN_CAP : cmd_len;
    end

    // Command state machine: latch, read burst, drain, write burst, done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            op_q    <= OP_NORM;
            fin_q   <= 1'b0;
            src_q   <= '0;
            src2_q  <= '0;
            dst_q   <= '0;
            len_q   <= '0;
            scale_q <= '0;
            shift_q <= '0;
            bias_q  <= '0;
            rd_ctr  <= '0;
            wr_ctr  <= '0;
        end else begin
            case (state)
                ST_IDLE: if (accept) begin
                    op_q    <= cmd_op;
                    fin_q   <= cmd_final;
                    src_q   <= cmd_src;
                    src2_q  <= cmd_src2;
                    dst_q   <= cmd_dst;
                    len_q   <= len_eff;
                    scale_q <= cmd_scale;
                    shift_q <= cmd_shift;
                    bias_q  <= cmd_bias;
                    rd_ctr  <= '0;
                    state   <= (len_eff == '0) ? ST_DONE : ST_READ;
                end
                ST_READ: begin
                    rd_ctr <= rd_ctr + 1'b1;
                    if (rd_ctr == len_q - 1'b1) state <= ST_DRAIN;
                end
                ST_DRAIN: if (!v1) begin
                    wr_ctr <= '0;
                    state  <= fin_q ? ST_DONE : ST_WRITE;
                end
                ST_WRITE: begin
                    wr_ctr <= wr_ctr + 1'b1;
                    if (wr_ctr == len_q - 1'b1) state <= ST_DONE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Read-data alignment, pool history and final-result output register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v1     <= 1'b0;
            v2     <= 1'b0;
            idx1   <= '0;
            idx2   <= '0;
            out_q  <= '0;
            prev_q <= '0;
        end else begin
            v1   <= (state == ST_READ);
            idx1 <= rd_ctr[IW-1:0];
            v2   <= v1 && fin_q;
            idx2 <= idx1;
            out_q <= alu_y;
            if (accept)  prev_q <= '0;
            else if (v1) prev_q <= rd_data_a;
        end
    end

    // Port-side strobes and addresses.
    always_comb begin
        cmd_ready   = (state == ST_IDLE);
        rd_en       = (state == ST_READ);
        rd_addr_a   = src_q + AW'(rd_ctr);
        rd_addr_b   = src2_q + AW'(rd_ctr);
        stg_wr_en   = v1 && !fin_q;
        stg_wr_idx  = idx1;
        stg_rd_idx  = wr_ctr[IW-1:0];
        acc_wr_en   = (state == ST_WRITE);
        acc_wr_addr = dst_q + AW'(wr_ctr);
        acc_wr_data = stg_rd_data;
        ub_wr_en    = v2;
        ub_wr_addr  = dst_q + AW'(idx2);
        ub_wr_data  = out_q;
        done        = (state == ST_DONE);
    end
endmodule

// File: rtl/vec_post_unit.sv
// Vector post-processing unit: reads accumulation-buffer vectors, applies a
// fixed-point elementwise or windowed operation and routes the result to the
// unified buffer (final) or back to the accumulation buffer (intermediate).
// Assumes both buffers are external with one-cycle synchronous reads.
module vec_post_unit
    import vpu_pkg::*;
#(
    parameter int AW      = 8,
    parameter int DW      = 16,
    parameter int SW      = 4,
    parameter int MAX_LEN = 16,
    parameter int LW      = $clog2(MAX_LEN + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    output logic          cmd_ready,
    input  logic [1:0]    cmd_op,
    input  logic          cmd_final,
    input  logic [AW-1:0] cmd_src,
    input  logic [AW-1:0] cmd_src2,
    input  logic [AW-1:0] cmd_dst,
    input  logic [LW-1:0] cmd_len,
    input  logic [DW-1:0] cmd_scale,
    input  logic [SW-1:0] cmd_shift,
    input  logic [DW-1:0] cmd_bias,
    output logic          acc_rd_en,
    output logic [AW-1:0] acc_rd_addr_a,
    input  logic [DW-1:0] acc_rd_data_a,
    output logic [AW-1:0] acc_rd_addr_b,
    input  logic [DW-1:0] acc_rd_data_b,
    output logic          acc_wr_en,
    output logic [AW-1:0] acc_wr_addr,
    output logic [DW-1:0] acc_wr_data,
    output logic          ub_wr_en,
    output logic [AW-1:0] ub_wr_addr,
    output logic [DW-1:0] ub_wr_data,
    output logic          done
);
    localparam int IW = (MAX_LEN > 1) ? $clog2(MAX_LEN) : 1;

    vpu_op_e       op_q;
    logic [DW-1:0] scale_q, bias_q, prev_q, alu_y;
    logic [SW-1:0] shift_q;
    logic          stg_wr_en;
    logic [IW-1:0] stg_wr_idx, stg_rd_idx;
    logic [DW-1:0] stg_rd_data;

    vpu_seq #(
        .AW(AW), .DW(DW), .SW(SW), .MAX_LEN(MAX_LEN), .LW(LW), .IW(IW)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_valid   (cmd_valid),
        .cmd_ready   (cmd_ready),
        .cmd_op      (vpu_op_e'(cmd_op)),
        .cmd_final   (cmd_final),
        .cmd_src     (cmd_src),
        .cmd_src2    (cmd_src2),
        .cmd_dst     (cmd_dst),
        .cmd_len     (cmd_len),
        .cmd_scale   (cmd_scale),
        .cmd_shift   (cmd_shift),
        .cmd_bias    (cmd_bias),
        .rd_en       (acc_rd_en),
        .rd_addr_a   (acc_rd_addr_a),
        .rd_addr_b   (acc_rd_addr_b),
        .rd_data_a   (acc_rd_data_a),
        .op_q        (op_q),
        .scale_q     (scale_q),
        .shift_q     (shift_q),
        .bias_q      (bias_q),
        .prev_q      (prev_q),
        .alu_y       (alu_y),
        .stg_wr_en   (stg_wr_en),
        .stg_wr_idx  (stg_wr_idx),
        .stg_rd_idx  (stg_rd_idx),
        .stg_rd_data (stg_rd_data),
        .acc_wr_en   (acc_wr_en),
        .acc_wr_addr (acc_wr_addr),
        .acc_wr_data (acc_wr_data),
        .ub_wr_en    (ub_wr_en),
        .ub_wr_addr  (ub_wr_addr),
        .ub_wr_data  (ub_wr_data),
        .done        (done)
    );

    vpu_alu #(.DW(DW), .SW(SW)) u_alu (
        .op    (op_q),
        .xa    (acc_rd_data_a),
        .xb    (acc_rd_data_b),
        .prev  (prev_q),
        .scale (scale_q),
        .bias  (bias_q),
        .shift (shift_q),
        .y     (alu_y)
    );

    vpu_stage_buf #(.DW(DW), .DEPTH(MAX_LEN), .IW(IW)) u_stage (
        .clk     (clk),
        .wr_en   (stg_wr_en),
        .wr_idx  (stg_wr_idx),
        .wr_data (alu_y),
        .rd_idx  (stg_rd_idx),
        .rd_data (stg_rd_data)
    );
endmodule

// File: rtl/vpu_post_chk.sv
// Port-level protocol checker for vec_post_unit, attached by bind.
// Assumes synchronous active-low reset held low at the first clock edge.
module vpu_post_chk #(
    parameter int AW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cmd_ready,
    input logic          acc_rd_en,
    input logic [AW-1:0] acc_rd_addr_a,
    input logic [AW-1:0] acc_rd_addr_b,
    input logic          acc_wr_en,
    input logic [AW-1:0] acc_wr_addr,
    input logic          ub_wr_en,
    input logic [AW-1:0] ub_wr_addr,
    input logic          done
);
    // R1
    reset_idle_chk: assert property (@(posedge clk)
        !rst_n |=> (cmd_ready && !done && !acc_wr_en && !ub_wr_en));

    // R2
    rd_addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_rd_en && $past(acc_rd_en)) |->
        (acc_rd_addr_a == AW'($past(acc_rd_addr_a) + 1'b1) &&
         acc_rd_addr_b == AW'($past(acc_rd_addr_b) + 1'b1)));

    // R7
    ub_addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ub_wr_en && $past(ub_wr_en)) |-> ub_wr_addr == AW'($past(ub_wr_addr) + 1'b1));

    // R8
    acc_addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_wr_en && $past(acc_wr_en)) |-> acc_wr_addr == AW'($past(acc_wr_addr) + 1'b1));

    // R8
    one_dest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc_wr_en && ub_wr_en));

    // R9
    write_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_wr_en |-> !acc_rd_en);

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && cmd_ready));

    // R10
    done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!acc_wr_en && !ub_wr_en && !acc_rd_en));
endmodule

bind vec_post_unit vpu_post_chk #(.AW(AW)) u_post_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cmd_ready     (cmd_ready),
    .acc_rd_en     (acc_rd_en),
    .acc_rd_addr_a (acc_rd_addr_a),
    .acc_rd_addr_b (acc_rd_addr_b),
    .acc_wr_en     (acc_wr_en),
    .acc_wr_addr   (acc_wr_addr),
    .ub_wr_en      (ub_wr_en),
    .ub_wr_addr    (ub_wr_addr),
    .done          (done)
);

// File: tb/vec_post_unit_test.sv
`timescale 1ns/1ps
// Directed bench for vec_post_unit: models both buffers, computes expected
// results from a pre-command snapshot, one task per scenario.
module vec_post_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic [1:0]  cmd_op = '0;
    logic        cmd_final = 1'b0;
    logic [7:0]  cmd_src = '0, cmd_src2 = '0, cmd_dst = '0;
    logic [4:0]  cmd_len = '0;
    logic [15:0] cmd_scale = '0, cmd_bias = '0;
    logic [3:0]  cmd_shift = '0;
    logic        acc_rd_en;
    logic [7:0]  acc_rd_addr_a, acc_rd_addr_b;
    logic [15:0] acc_rd_data_a = '0, acc_rd_data_b = '0;
    logic        acc_wr_en, ub_wr_en, done;
    logic [7:0]  acc_wr_addr, ub_wr_addr;
    logic [15:0] acc_wr_data, ub_wr_data;

    always #2.5 clk = ~clk;

    vec_post_unit uut (.*);

    logic signed [15:0] acc_mem [256];
    logic signed [15:0] ub_mem  [256];
    logic signed [15:0] snap    [256];
    int cyc = 0, ub_cnt = 0, acc_cnt = 0, rd_cnt = 0, last_wr = -1, done_cyc = -1;
    int checks = 0, failures = 0;

    // Buffer model with one-cycle reads, plus write/done monitors.
    always @(posedge clk) begin
        if (acc_rd_en) begin
            acc_rd_data_a <= acc_mem[acc_rd_addr_a];
            acc_rd_data_b <= acc_mem[acc_rd_addr_b];
            rd_cnt++;
        end
        if (acc_wr_en) begin acc_mem[acc_wr_addr] = acc_wr_data; acc_cnt++; last_wr = cyc; end
        if (ub_wr_en)  begin ub_mem[ub_wr_addr]   = ub_wr_data;  ub_cnt++;  last_wr = cyc; end
        if (done) done_cyc = cyc;
        cyc++;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int sat16(input longint v);
        if (v > 32767) return 32767;
        if (v < -32768) return -32768;
        return int'(v);
    endfunction

    function automatic int expect_elem(input int op, input int i, input int src, input int src2,
                                       input int scale, input int shift, input int bias);
        longint x, y, p, v;
        x = snap[(src + i) & 255];
        y = snap[(src2 + i) & 255];
        p = (i == 0) ? 0 : snap[(src + i - 1) & 255];
        case (op)
            0: begin v = (x * scale) >>> shift; return sat16(v + bias); end
            1: return (x < 0) ? 0 : int'(x);
            2: return sat16(x + y);
            default: return int'((x > p) ? x : p);
        endcase
    endfunction

    // Issue one command, wait for done, check routing, counts, timing, data.
    task automatic run_cmd(input int op, input bit fin, input int src, input int src2,
                           input int dst, input int len, input int scale, input int shift,
                           input int bias, input string req);
        int t = 0;
        int n = (len > 16) ? 16 : len;
        int got;
        for (int k = 0; k < 256; k++) snap[k] = acc_mem[k];
        ub_cnt = 0; acc_cnt = 0; rd_cnt = 0; last_wr = -1; done_cyc = -1;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op[1:0]; cmd_final = fin;
        cmd_src = src[7:0]; cmd_src2 = src2[7:0]; cmd_dst = dst[7:0];
        cmd_len = len[4:0]; cmd_scale = scale[15:0]; cmd_shift = shift[3:0]; cmd_bias = bias[15:0];
        @(negedge clk);
        cmd_valid = 1'b0;
        while (!done && t < 200) begin @(negedge clk); t++; end
        chk(done == 1'b1, "R10 done seen", int'(done), 1);
        @(negedge clk);
        chk(cmd_ready == 1'b1, "R10 ready after done", int'(cmd_ready), 1);
        chk(done == 1'b0, "R10 done one cycle", int'(done), 0);
        chk(rd_cnt == n, "R2 read count", rd_cnt, n);
        if (n > 0) chk(done_cyc == last_wr + 1, "R10 done after last write", done_cyc, last_wr + 1);
        if (fin) begin
            chk(ub_cnt == n && acc_cnt == 0, "R7 final routing", ub_cnt * 1000 + acc_cnt, n * 1000);
        end else begin
            chk(acc_cnt == n && ub_cnt == 0, "R8 intermediate routing", acc_cnt * 1000 + ub_cnt, n * 1000);
        end
        for (int i = 0; i < n; i++) begin
            int e = expect_elem(op, i, src, src2, scale, shift, bias);
            got = fin ? int'(ub_mem[(dst + i) & 255]) : int'(acc_mem[(dst + i) & 255]);
            chk(got == e, req, got, e);
        end
    endtask

    task automatic t_reset();
        chk(cmd_ready == 1'b1 && done == 1'b0, "R1 idle after reset", int'(cmd_ready), 1);
        chk(!acc_wr_en && !ub_wr_en, "R1 no writes after reset", int'(acc_wr_en | ub_wr_en), 0);
    endtask

    task automatic t_norm();
        int v [6] = '{10, -7, 300, 20000, -20000, 0};
        for (int i = 0; i < 6; i++) acc_mem[20 + i] = 16'(v[i]);
        run_cmd(0, 1'b1, 20, 0, 60, 6, 3, 1, -5, "R3 normalize");
        run_cmd(0, 1'b1, 20, 0, 70, 6, 200, 0, 100, "R3 normalize saturate");
    endtask

    task automatic t_relu();
        int v [5] = '{-1, 0, 5, -32768, 32767};
        for (int i = 0; i < 5; i++) acc_mem[30 + i] = 16'(v[i]);
        run_cmd(1, 1'b0, 30, 0, 200, 5, 0, 0, 0, "R4 rectify to accumulation R8");
    endtask

    task automatic t_add();
        int a [4] = '{30000, -30000, 12, -1};
        int b [4] = '{10000, -10000, -20, 1};
        for (int i = 0; i < 4; i++) begin acc_mem[80 + i] = 16'(a[i]); acc_mem[90 + i] = 16'(b[i]); end
        run_cmd(2, 1'b1, 80, 90, 110, 4, 0, 0, 0, "R5 saturating add");
    endtask

    task automatic t_pool();
        int v [6] = '{-9, 4, 2, 7, -3, -8};
        for (int i = 0; i < 6; i++) acc_mem[120 + i] = 16'(v[i]);
        run_cmd(3, 1'b1, 120, 0, 130, 6, 0, 0, 0, "R6 pool with zero pad");
        chk(ub_mem[130] == 0, "R6 padded first element", int'(ub_mem[130]), 0);
    endtask

    task automatic t_overlap();
        for (int i = 0; i < 8; i++) acc_mem[40 + i] = 16'(((i % 2) == 1) ? -(i + 1) * 11 : (i + 1) * 13);
        run_cmd(1, 1'b0, 40, 0, 43, 8, 0, 0, 0, "R9 overlap uses old values");
    endtask

    task automatic t_lengths();
        ub_mem[166] = 16'sd31000;
        run_cmd(1, 1'b1, 10, 0, 150, 0, 0, 0, 0, "R11 zero length");
        chk(ub_cnt == 0 && acc_cnt == 0, "R11 zero length no writes", ub_cnt + acc_cnt, 0);
        run_cmd(3, 1'b1, 100, 0, 150, 20, 0, 0, 0, "R11 clamped length");
        chk(ub_mem[166] == 16'sd31000, "R11 no write past cap", int'(ub_mem[166]), 31000);
    endtask

    // Watchdog: a hung run is a failure that still reaches the summary.
    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int k = 0; k < 256; k++) begin
            acc_mem[k] = 16'(((k * 37) % 200) - 100);
            ub_mem[k]  = 16'sd0;
        end
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_norm();
        t_relu();
        t_add();
        t_pool();
        t_overlap();
        t_lengths();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule